// File: doc/BRIEF.md
# Open-Drain Two-Wire GPIO Port With Per-Bit Write Enables

This block gives software direct control of several pairs of open-drain pins, each pair being a clock line and a data line of a two-wire bus that software bit-bangs (for example a general I2C bus and a display identification bus). Each pin holds a drive bit and a level bit. The pad is pulled low only while the pin drives a 0. In every other case the pad is released and the external pull-up takes the line high.

Each port is one 32-bit register. Every drive bit and every level bit in that register has its own write-enable bit beside it, so a single store can change one field without reading the register first. Each pin also has a sampled-input bit, which is read-only. This bit takes the synchronized pad level on any write to its port, but only while the pin is an input. A write of all zeros is therefore enough to refresh the sampled inputs.

Register access uses a valid/ready request channel. Reads return their data one cycle after the request. The ports sit at word offsets 0x10, 0x14 and so on within the block's window. Every other offset reads as zero and ignores writes.

Top module: `od_gpio_port`

## Requirements
- R1: After reset every pin is an input with level 1 and sampled input 0. Each port therefore reads 0x00000808 and no pad is pulled low.
- R2: Port bit 1 (clock pin) and bit 9 (data pin) hold the drive flag, where 1 means drive. Each flag takes the written value only when bit 0 (or bit 8) of the same write is 1. Otherwise it keeps its value.
- R3: Port bit 3 (clock) and bit 11 (data) hold the level. Each level takes the written value only when bit 2 (or bit 10) of the same write is 1. Otherwise it keeps its value.
- R4: A pad's pull-low output is 1 exactly when its pin drives and its level is 0. The output follows the register contents from the cycle after the write.
- R5: A write to a port copies the synchronized pad level into bit 4 (clock) or bit 12 (data) for each pin that is an input, even when the write data is all zeros. The copied value then holds until the next write, whatever the pad does.
- R6: The input test uses the drive flag as it stood before the write. A write that makes an input pin drive still captures that pin. A write that makes a driving pin an input does not capture it.
- R7: A read accepted at one clock edge raises the response valid for exactly one cycle after that edge. The response carries the drive, level and sampled bits at their positions and zeros in all write-enable bits and unused bits.
- R8: Port k sits at offset 0x10 + 4k and controls pad pair k only. Writing one port leaves the pads and readback of every other port unchanged.
- R9: An offset that matches no port, including offset 0x00 and misaligned offsets, ignores writes. A read from such an offset returns 0 with a normal response.
- R10: Pad inputs pass through a two-flop synchronizer. A pad change presented just before the edge that accepts a write is not captured by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block accepts requests (high once out of reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| pad_scl_in | input | NUM_PORTS | Clock pad levels, one per port |
| pad_sda_in | input | NUM_PORTS | Data pad levels, one per port |
| pad_scl_pull | output | NUM_PORTS | Pull clock pad low, one per port |
| pad_sda_pull | output | NUM_PORTS | Pull data pad low, one per port |

## Verification
A single write both applies its masked updates to the drive flags and decides whether each pin's input is captured, so the two functions meet on one clock edge. The bench provokes this meeting from both sides. One write turns an input into a driver, and the sampled bit must still take the pad level. Another write turns a driver into an input while the pad differs from the stored bit, and the sampled bit must stay unchanged. A third case changes a pad just before the write edge, and the read that follows must show the value the synchronizer still held.

// File: rtl/gpod_pkg.sv
package gpod_pkg;
  // Bit positions inside one pin lane of a port register
  localparam int FLD_DIR_WE = 0;
  localparam int FLD_DIR    = 1;
  localparam int FLD_LVL_WE = 2;
  localparam int FLD_LVL    = 3;
  localparam int FLD_SMP    = 4;
  // Lane offsets: clock pin and data pin
  localparam int LANE_STRIDE = 8;
  localparam int NUM_LANES   = 2;

  typedef struct packed {
    logic drive;
    logic level;
    logic smp;
  } pin_state_t;
endpackage

// File: rtl/gpod_sync.sv
module gpod_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpod_pin.sv
module gpod_pin
  import gpod_pkg::*;
#(
  parameter int LANE   = 0,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pad_sync,
  output pin_state_t        state,
  output logic              pull_low
);
  pin_state_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    if (wdata[LANE+FLD_DIR_WE]) nxt.drive = wdata[LANE+FLD_DIR];
    if (wdata[LANE+FLD_LVL_WE]) nxt.level = wdata[LANE+FLD_LVL];
    // capture decided by the direction held before this write
    if (!cur_q.drive)           nxt.smp   = pad_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q.drive <= 1'b0;
      cur_q.level <= 1'b1;
      cur_q.smp   <= 1'b0;
    end else if (wr_en) begin
      cur_q <= nxt;
    end
  end

  assign state    = cur_q;
  assign pull_low = cur_q.drive & ~cur_q.level;
endmodule

// File: rtl/gpod_port.sv
module gpod_port
  import gpod_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LANES-1:0] pad_in,
  output logic [NUM_LANES-1:0] pull_low,
  output logic [DATA_W-1:0]    rd_word
);
  pin_state_t           st [NUM_LANES];
  logic [NUM_LANES-1:0] pad_sync;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    gpod_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in[l]),
      .q     (pad_sync[l])
    );
    gpod_pin #(.LANE(l*LANE_STRIDE), .DATA_W(DATA_W)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wdata    (wdata),
      .pad_sync (pad_sync[l]),
      .state    (st[l]),
      .pull_low (pull_low[l])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      rd_word[l*LANE_STRIDE+FLD_DIR] = st[l].drive;
      rd_word[l*LANE_STRIDE+FLD_LVL] = st[l].level;
      rd_word[l*LANE_STRIDE+FLD_SMP] = st[l].smp;
    end
  end
endmodule

// File: rtl/od_gpio_port.sv
module od_gpio_port
  import gpod_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int PORT_BASE   = 'h10,
  parameter int PORT_STRIDE = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic [NUM_PORTS-1:0] pad_scl_in,
  input  logic [NUM_PORTS-1:0] pad_sda_in,
  output logic [NUM_PORTS-1:0] pad_scl_pull,
  output logic [NUM_PORTS-1:0] pad_sda_pull
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];
  assign req_ready = rst_int_n;

  logic                 accept;
  logic [NUM_PORTS-1:0] hit;
  logic [DATA_W-1:0]    port_word [NUM_PORTS];
  logic [DATA_W-1:0]    rd_mux;
  logic                 rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0]    rsp_rdata_q, rsp_rdata_d;

  assign accept = req_valid & req_ready;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] P_ADDR = ADDR_W'(PORT_BASE + p*PORT_STRIDE);
    logic [NUM_LANES-1:0] pads;
    logic [NUM_LANES-1:0] pulls;

    assign hit[p] = (req_addr == P_ADDR);
    assign pads   = {pad_sda_in[p], pad_scl_in[p]};

    gpod_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_port (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .wr_en    (accept & req_write & hit[p]),
      .wdata    (req_wdata),
      .pad_in   (pads),
      .pull_low (pulls),
      .rd_word  (port_word[p])
    );

    assign pad_scl_pull[p] = pulls[0];
    assign pad_sda_pull[p] = pulls[1];
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hit[p]) rd_mux = rd_mux | port_word[p];
    end
  end

  always_comb begin
    rsp_valid_d = accept & ~req_write;
    rsp_rdata_d = rsp_rdata_q;
    if (rsp_valid_d) rsp_rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/gpod_checker.sv
module gpod_checker #(
  parameter int NUM_PORTS   = 2,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int PORT_BASE   = 'h10,
  parameter int PORT_STRIDE = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [DATA_W-1:0]    req_wdata,
  input logic                 rsp_valid,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic [NUM_PORTS-1:0] pad_scl_pull,
  input logic [NUM_PORTS-1:0] pad_sda_pull
);
  logic mapped;
  logic rd_acc, wr_acc;
  logic [DATA_W-1:0] we_bits;

  always_comb begin
    mapped = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (req_addr == ADDR_W'(PORT_BASE + p*PORT_STRIDE)) mapped = 1'b1;
    end
  end

  assign rd_acc  = req_valid & req_ready & ~req_write;
  assign wr_acc  = req_valid & req_ready & req_write;
  assign we_bits = DATA_W'(32'h0000_0505);

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid); // R7
  AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_acc)); // R7
  AST_RSP_WE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & we_bits) == '0)); // R7
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !mapped) |=> (rsp_rdata == '0)); // R9
  AST_UNMAPPED_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !mapped) |=> ($stable(pad_scl_pull) && $stable(pad_sda_pull))); // R9
  AST_NO_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && mapped && ((req_wdata & we_bits) == '0))
      |=> ($stable(pad_scl_pull) && $stable(pad_sda_pull))); // R2
endmodule

bind od_gpio_port gpod_checker #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .PORT_BASE(PORT_BASE), .PORT_STRIDE(PORT_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .pad_scl_pull(pad_scl_pull), .pad_sda_pull(pad_sda_pull)
);

// File: tb/od_gpio_port_bench.sv
module od_gpio_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  scl_in, sda_in, scl_pull, sda_pull;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  od_gpio_port u_od_gpio_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pad_scl_in(scl_in), .pad_sda_in(sda_in),
    .pad_scl_pull(scl_pull), .pad_sda_pull(sda_pull)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk({tag, " rsp one cycle"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic pulls(input logic [3:0] exp, input string tag);
    @(negedge clk);
    chk(tag, {28'd0, sda_pull[1], scl_pull[1], sda_pull[0], scl_pull[0]}, {28'd0, exp});
  endtask

  // monitor: compare each read response with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected response", 32'd1, 32'd0);
      end else begin
        chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; scl_in = 2'b11; sda_in = 2'b11;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 ready after reset", {31'd0, req_ready}, 32'd1);

    // R1 reset state
    rd(12'h010, 32'h0000_0808, "R1 port0 reset");
    rd(12'h014, 32'h0000_0808, "R1 port1 reset");
    pulls(4'b0000, "R1 no pull after reset");

    // R2 drive flag with its enable; captures both inputs (R5)
    wr(12'h010, 32'h0000_0003);
    rd(12'h010, 32'h0000_181A, "R2 clock drive set");
    pulls(4'b0000, "R4 drive high released");
    // R3 level with its enable
    wr(12'h010, 32'h0000_0004);
    rd(12'h010, 32'h0000_1812, "R3 clock level cleared");
    pulls(4'b0001, "R4 drive low pulls");
    // R2/R3 without enables nothing changes
    wr(12'h010, 32'h0000_0A08);
    rd(12'h010, 32'h0000_1812, "R3 level held without enable");
    pulls(4'b0001, "R2 pads held without enable");

    // R5 held between writes, captured by all-zero write
    sda_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd(12'h010, 32'h0000_1812, "R5 sampled holds without write");
    wr(12'h010, 32'h0000_0000);
    rd(12'h010, 32'h0000_0812, "R5 zero write captures");

    // R6 capture uses direction before the write
    sda_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    wr(12'h010, 32'h0000_0300);
    rd(12'h010, 32'h0000_1A12, "R6 input-to-drive still captures");
    sda_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    wr(12'h010, 32'h0000_0100);
    rd(12'h010, 32'h0000_1812, "R6 drive-to-input no capture");
    wr(12'h010, 32'h0000_0000);
    rd(12'h010, 32'h0000_0812, "R6 later write captures");

    // R10 synchronizer latency
    @(negedge clk);
    sda_in[0] = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h010; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd(12'h010, 32'h0000_0812, "R10 late pad change not seen");
    wr(12'h010, 32'h0000_0000);
    rd(12'h010, 32'h0000_1812, "R10 settled pad captured");

    // R8 second port independent
    wr(12'h014, 32'h0000_0F0F);
    rd(12'h014, 32'h0000_1A1A, "R8 port1 drive high");
    pulls(4'b0001, "R8 port1 released");
    wr(12'h014, 32'h0000_0404);
    rd(12'h014, 32'h0000_1212, "R8 port1 drive low");
    pulls(4'b1101, "R4 port1 both pulled");
    rd(12'h010, 32'h0000_1812, "R8 port0 unchanged");

    // R9 unmapped offsets
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h012, 32'h0000_0F0F);
    pulls(4'b1101, "R9 unmapped writes ignored");
    rd(12'h010, 32'h0000_1812, "R9 port0 untouched");
    rd(12'h014, 32'h0000_1212, "R9 port1 untouched");
    rd(12'h000, 32'h0000_0000, "R9 offset zero reads zero");
    rd(12'h018, 32'h0000_0000, "R9 past last port reads zero");

    // init pattern: all pins drive 1
    wr(12'h010, 32'h0000_0F0F);
    wr(12'h014, 32'h0000_0F0F);
    pulls(4'b0000, "R4 init releases all");
    rd(12'h010, 32'h0000_1A1A, "R2 port0 init readback");

    repeat (3) @(negedge clk);
    chk("R7 scoreboard drained", exp_q.size(), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule